// File: doc/BRIEF.md
# Token-Passing Column Readout Arbiter

This block is the readout core for a group of pixel columns. It reads only hit data and needs no trigger. Each column's end-of-column logic connects through a request port. A column asserts its request while it holds hits. It presents its current hit on the port: a row number, an ADC code, a beam-crossing tag, and a flag that marks the last hit. A single horizontal token visits the requesting columns in ascending index order. The column holding the token drives one hit per readout clock onto a 23-bit output bus. It receives a one-cycle advance strobe for each hit taken, and steps to its next hit on that strobe.

The output word puts the column's own 5-bit code next to the hit fields, so a downstream unit can identify the source column. No column code has its two low bits equal to zero. The token stops at the next requesting column with no wasted cycle between columns. Each time the token runs off the top of the column range, the bus carries exactly two empty cycles: one silent cycle, then one cycle to relaunch the token.

Top module: `col_token_readout`

## Requirements
- R1: While synchronous active-high reset is applied, and on the first cycle after it, `out_valid` is 0, `out_word` is 0 and `col_adv` is all zero.
- R2: When the token is inactive and any column request is high, the token launches at the next clock edge. The launch cycle itself is empty, so the first hit appears two cycles after the request is first seen.
- R3: In each cycle a talking column has its hit on the bus, exactly that column's bit of `col_adv` is high. `col_adv` is never high for a column whose request is low.
- R4: A talking column drives one hit per cycle. It keeps the token, with `out_valid` high, until it drives the hit whose last flag is set.
- R5: In the cycle after the last hit of a column, the next requesting column above it drives its first hit, with no empty cycle in between. Each column keeps its request high until its last hit is taken.
- R6: When no requesting column exists above the one that just finished, the bus is empty for exactly two cycles before the next hit.
- R7: Within one sweep, columns are served in ascending index order. A column that raises its request below the token's position waits for the next sweep.
- R8: Output word layout: bits [6:0] hold the row, bits [9:7] the ADC code, bits [14:10] the column code, and bits [22:15] the beam-crossing tag.
- R9: The code of column k is the k-th value, counting from zero in ascending order, among the 5-bit values whose two low bits are not 00 (1, 2, 3, 5, 6, 7, 9, ...). Bits [11:10] of a valid word are therefore never 00.
- R10: Whenever `out_valid` is 0, `out_word` is all zero and no advance strobe is given.
- R11: A reset applied mid-column drops the token. Hits still pending are served after a fresh launch, which has the same two empty cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Readout clock |
| rst | input | 1 | Synchronous active-high reset |
| col_req | input | NCOL | Per-column request: column holds at least one hit |
| col_last | input | NCOL | Per-column flag: presented hit is the column's last |
| col_row | input | NCOL*7 | Per-column row number of the presented hit |
| col_adc | input | NCOL*3 | Per-column ADC code of the presented hit |
| col_bco | input | NCOL*8 | Per-column beam-crossing tag of the presented hit |
| col_adv | output | NCOL | Per-column strobe: presented hit taken this cycle |
| out_valid | output | 1 | Output bus carries a hit |
| out_word | output | 23 | Packed hit word, zero when not valid |

## Verification
Two functions can fall in the same cycle: the hand-off from a column's last hit, and the search for the next requester. The search must find or miss a column whose request rose while the token was already past it, or just ahead of it. The bench provokes this by adding hits to one column below and one column above the token while a column is still talking. It then judges the resulting code sequence and the empty-cycle count against its own queue model: the upper column must follow with no gap, and the lower one only after exactly two empty cycles. The same model checks every cycle of a drain in which all columns request at once and hand off back to back.

// File: rtl/colrd_pkg.sv
package colrd_pkg;

  localparam int ROW_W  = 7;
  localparam int ADC_W  = 3;
  localparam int CODE_W = 5;
  localparam int BCO_W  = 8;
  localparam int WORD_W = ROW_W + ADC_W + CODE_W + BCO_W;

  // bit position of the column code inside the packed word
  localparam int CODE_LO = ROW_W + ADC_W;

  typedef enum logic [1:0] {
    TK_IDLE = 2'd0,
    TK_SEEK = 2'd1,
    TK_TALK = 2'd2
  } tok_state_e;

  // k-th value whose two low bits are nonzero: three usable codes per group of four
  function automatic logic [CODE_W-1:0] col_code(input int unsigned k);
    int unsigned v;
    v = (k / 3) * 4 + (k % 3) + 1;
    return v[CODE_W-1:0];
  endfunction

  function automatic logic [WORD_W-1:0] pack_hit(
    input logic [ROW_W-1:0]  row,
    input logic [ADC_W-1:0]  adc,
    input logic [CODE_W-1:0] code,
    input logic [BCO_W-1:0]  bco
  );
    return {bco, code, adc, row};
  endfunction

endpackage

// File: rtl/col_first_req.sv
module col_first_req #(
  parameter int N  = 22,
  parameter int IW = 5
) (
  input  logic [N-1:0]  req,
  input  logic [IW:0]   start,
  output logic          found,
  output logic [IW-1:0] idx
);
  // lowest requesting index at or above start; scanning downward lets the lowest win
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int k = N - 1; k >= 0; k--) begin
      if (req[k] && (k >= int'(start))) begin
        found = 1'b1;
        idx   = IW'(k);
      end
    end
  end
endmodule

// File: rtl/col_field_mux.sv
module col_field_mux
  import colrd_pkg::*;
#(
  parameter int N  = 22,
  parameter int IW = 5
) (
  input  logic [IW-1:0]      sel,
  input  logic [N-1:0]       req,
  input  logic [N-1:0]       last,
  input  logic [N*ROW_W-1:0] row_flat,
  input  logic [N*ADC_W-1:0] adc_flat,
  input  logic [N*BCO_W-1:0] bco_flat,
  output logic               sel_req,
  output logic               sel_last,
  output logic [ROW_W-1:0]   sel_row,
  output logic [ADC_W-1:0]   sel_adc,
  output logic [BCO_W-1:0]   sel_bco
);
  logic [ROW_W-1:0] row_a [N];
  logic [ADC_W-1:0] adc_a [N];
  logic [BCO_W-1:0] bco_a [N];

  for (genvar g = 0; g < N; g++) begin : g_unpack
    assign row_a[g] = row_flat[g*ROW_W +: ROW_W];
    assign adc_a[g] = adc_flat[g*ADC_W +: ADC_W];
    assign bco_a[g] = bco_flat[g*BCO_W +: BCO_W];
  end

  assign sel_req  = req[sel];
  assign sel_last = last[sel];
  assign sel_row  = row_a[sel];
  assign sel_adc  = adc_a[sel];
  assign sel_bco  = bco_a[sel];
endmodule

// File: rtl/hit_word_pack.sv
module hit_word_pack
  import colrd_pkg::*;
#(
  parameter int IW = 5
) (
  input  logic              drive,
  input  logic [IW-1:0]     col_idx,
  input  logic [ROW_W-1:0]  row,
  input  logic [ADC_W-1:0]  adc,
  input  logic [BCO_W-1:0]  bco,
  output logic [WORD_W-1:0] word
);
  always_comb begin
    if (drive) word = pack_hit(row, adc, col_code(32'(col_idx)), bco);
    else       word = '0;
  end
endmodule

// File: rtl/col_token_readout.sv
module col_token_readout
  import colrd_pkg::*;
#(
  parameter int NCOL = 22,
  localparam int IW  = $clog2(NCOL)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NCOL-1:0]       col_req,
  input  logic [NCOL-1:0]       col_last,
  input  logic [NCOL*ROW_W-1:0] col_row,
  input  logic [NCOL*ADC_W-1:0] col_adc,
  input  logic [NCOL*BCO_W-1:0] col_bco,
  output logic [NCOL-1:0]       col_adv,
  output logic                  out_valid,
  output logic [WORD_W-1:0]     out_word
);
  tok_state_e state_q, state_d;
  logic [IW-1:0] col_q, col_d;

  logic          sel_req, sel_last;
  logic [ROW_W-1:0] sel_row;
  logic [ADC_W-1:0] sel_adc;
  logic [BCO_W-1:0] sel_bco;

  logic [IW:0]   search_start;
  logic          found;
  logic [IW-1:0] found_idx;

  // named events, observed by the bound checker
  logic talking, col_done, launch, handoff, sweep_end;

  col_field_mux #(.N(NCOL), .IW(IW)) u_mux (
    .sel      (col_q),
    .req      (col_req),
    .last     (col_last),
    .row_flat (col_row),
    .adc_flat (col_adc),
    .bco_flat (col_bco),
    .sel_req  (sel_req),
    .sel_last (sel_last),
    .sel_row  (sel_row),
    .sel_adc  (sel_adc),
    .sel_bco  (sel_bco)
  );

  // a fresh launch scans from column 0; a finishing column scans strictly above itself
  assign search_start = (state_q == TK_SEEK) ? '0 : ({1'b0, col_q} + (IW+1)'(1));

  col_first_req #(.N(NCOL), .IW(IW)) u_find (
    .req   (col_req),
    .start (search_start),
    .found (found),
    .idx   (found_idx)
  );

  assign talking   = (state_q == TK_TALK) && sel_req;
  assign col_done  = (state_q == TK_TALK) && (!sel_req || sel_last);
  assign launch    = (state_q == TK_IDLE) && (|col_req);
  assign handoff   = col_done && found;
  assign sweep_end = col_done && !found;

  always_comb begin
    state_d = state_q;
    col_d   = col_q;
    unique case (state_q)
      TK_IDLE: if (launch) state_d = TK_SEEK;
      TK_SEEK: begin
        if (found) begin
          state_d = TK_TALK;
          col_d   = found_idx;
        end else begin
          state_d = TK_IDLE;
        end
      end
      TK_TALK: begin
        if (handoff)        col_d   = found_idx;
        else if (sweep_end) state_d = TK_IDLE;
      end
      default: state_d = TK_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= TK_IDLE;
      col_q   <= '0;
    end else begin
      state_q <= state_d;
      col_q   <= col_d;
    end
  end

  for (genvar g = 0; g < NCOL; g++) begin : g_adv
    assign col_adv[g] = talking && (col_q == IW'(g));
  end

  assign out_valid = talking;

  hit_word_pack #(.IW(IW)) u_pack (
    .drive   (talking),
    .col_idx (col_q),
    .row     (sel_row),
    .adc     (sel_adc),
    .bco     (sel_bco),
    .word    (out_word)
  );
endmodule

// File: rtl/colrd_chk.sv
module colrd_chk
  import colrd_pkg::*;
#(
  parameter int NCOL = 22
) (
  input logic              clk,
  input logic              rst,
  input logic [NCOL-1:0]   col_req,
  input logic [NCOL-1:0]   col_adv,
  input logic              out_valid,
  input logic [WORD_W-1:0] out_word,
  input logic              launch,
  input logic              handoff,
  input logic              sweep_end
);
  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> (out_word == '0 && col_adv == '0));

  a_r3_single_grant: assert property (@(posedge clk) disable iff (rst)
    $onehot0(col_adv));

  a_r3_grant_needs_req: assert property (@(posedge clk) disable iff (rst)
    (col_adv & ~col_req) == '0);

  a_r4_valid_has_grant: assert property (@(posedge clk) disable iff (rst)
    out_valid == (|col_adv));

  a_r9_code_low_bits: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_word[CODE_LO +: 2] != 2'b00));

  a_r7_code_ascends: assert property (@(posedge clk) disable iff (rst)
    (out_valid && $past(out_valid)) |->
      (out_word[CODE_LO +: CODE_W] >= $past(out_word[CODE_LO +: CODE_W])));

  a_r2_launch_empty: assert property (@(posedge clk) disable iff (rst)
    launch |=> !out_valid);

  a_r5_no_gap: assert property (@(posedge clk) disable iff (rst)
    handoff |=> out_valid);

  a_r6_sweep_silent: assert property (@(posedge clk) disable iff (rst)
    sweep_end |=> !out_valid);
endmodule

bind col_token_readout colrd_chk #(.NCOL(NCOL)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .col_req   (col_req),
  .col_adv   (col_adv),
  .out_valid (out_valid),
  .out_word  (out_word),
  .launch    (launch),
  .handoff   (handoff),
  .sweep_end (sweep_end)
);

// File: tb/tb_col_token_readout.sv
`timescale 1ns/1ps
module tb_col_token_readout;
  import colrd_pkg::*;

  localparam int NCOL = 22;
  localparam int PER  = 4;

  logic                  clk = 1'b0;
  logic                  rst = 1'b1;
  logic [NCOL-1:0]       col_req  = '0;
  logic [NCOL-1:0]       col_last = '0;
  logic [NCOL*ROW_W-1:0] col_row  = '0;
  logic [NCOL*ADC_W-1:0] col_adc  = '0;
  logic [NCOL*BCO_W-1:0] col_bco  = '0;
  logic [NCOL-1:0]       col_adv;
  logic                  out_valid;
  logic [WORD_W-1:0]     out_word;

  always #(PER/2) clk = ~clk;

  col_token_readout #(.NCOL(NCOL)) dut (
    .clk(clk), .rst(rst), .col_req(col_req), .col_last(col_last),
    .col_row(col_row), .col_adc(col_adc), .col_bco(col_bco),
    .col_adv(col_adv), .out_valid(out_valid), .out_word(out_word)
  );

  typedef struct { int row; int adc; int bco; } hit_t;
  hit_t hq [NCOL][$];

  int mst = 0;   // 0 idle, 1 launching, 2 talking
  int mcol = 0;
  int nrun = 0, nfail = 0;
  int empties = 0;
  int seq_codes [$];

  // independent restatement of the code list: skip every value that is a multiple of four
  function automatic int ref_code(int k);
    int cnt = -1;
    for (int v = 1; v < 32; v++) begin
      if (v % 4 != 0) cnt++;
      if (cnt == k) return v;
    end
    return -1;
  endfunction

  function automatic int first_from(int s);
    for (int k = s; k < NCOL; k++) if (hq[k].size() > 0) return k;
    return -1;
  endfunction

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    nrun++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic drive_cols();
    for (int k = 0; k < NCOL; k++) begin
      if (hq[k].size() > 0) begin
        col_req[k]  = 1'b1;
        col_last[k] = (hq[k].size() == 1);
        col_row[k*ROW_W +: ROW_W] = ROW_W'(hq[k][0].row);
        col_adc[k*ADC_W +: ADC_W] = ADC_W'(hq[k][0].adc);
        col_bco[k*BCO_W +: BCO_W] = BCO_W'(hq[k][0].bco);
      end else begin
        col_req[k]  = 1'b0;
        col_last[k] = 1'b0;
        col_row[k*ROW_W +: ROW_W] = '0;
        col_adc[k*ADC_W +: ADC_W] = '0;
        col_bco[k*BCO_W +: BCO_W] = '0;
      end
    end
  endtask

  task automatic step();
    logic              ev;
    logic [WORD_W-1:0] ew;
    logic [NCOL-1:0]   ea, got_adv;
    int nst, ncol, f;
    @(negedge clk);
    drive_cols();
    #1;
    ev = 1'b0; ew = '0; ea = '0; nst = mst; ncol = mcol;
    case (mst)
      0: if (first_from(0) >= 0) nst = 1;
      1: begin
        f = first_from(0);
        if (f >= 0) begin nst = 2; ncol = f; end else nst = 0;
      end
      default: begin
        if (hq[mcol].size() > 0) begin
          ev = 1'b1;
          ew = {BCO_W'(hq[mcol][0].bco), CODE_W'(ref_code(mcol)),
                ADC_W'(hq[mcol][0].adc), ROW_W'(hq[mcol][0].row)};
          ea[mcol] = 1'b1;
        end
        if (!ev || hq[mcol].size() == 1) begin
          f = first_from(mcol + 1);
          if (f >= 0) ncol = f; else nst = 0;
        end
      end
    endcase
    chk(out_valid == ev, "R4", "valid", out_valid, ev);
    chk(out_word == ew, "R8", "word", out_word, ew);
    chk(col_adv == ea, "R3", "advance", col_adv, ea);
    if (!ev) chk(out_word == '0 && col_adv == '0, "R10", "idle bus", out_word, 0);
    if (out_valid) seq_codes.push_back(int'(out_word[CODE_LO +: CODE_W]));
    else empties++;
    got_adv = col_adv;
    @(posedge clk);
    #1;
    for (int k = 0; k < NCOL; k++)
      if (got_adv[k] && hq[k].size() > 0) void'(hq[k].pop_front());
    mst  = rst ? 0 : nst;
    mcol = rst ? 0 : ncol;
  endtask

  task automatic add_hits(int col, int n);
    for (int i = 0; i < n; i++) begin
      hit_t h;
      h.row = (col * 5 + i * 3 + 1) % 128;
      h.adc = (col + i) % 8;
      h.bco = (col * 11 + i * 7 + 3) % 256;
      hq[col].push_back(h);
    end
  endtask

  task automatic clear_log();
    empties = 0;
    seq_codes.delete();
  endtask

  // runs until every column is empty; returns the empty cycles seen meanwhile
  task automatic drain(output int gaps);
    int guard = 0;
    while (first_from(0) >= 0 && guard < 5000) begin
      step();
      guard++;
    end
    gaps = empties;
    step();
    step();
  endtask

  task automatic check_seq(int exp_q[$], string req);
    chk(seq_codes.size() == exp_q.size(), req, "hit count", seq_codes.size(), exp_q.size());
    for (int i = 0; i < exp_q.size() && i < seq_codes.size(); i++)
      chk(seq_codes[i] == exp_q[i], req, "column order", seq_codes[i], exp_q[i]);
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", nrun, nfail);
  endtask

  initial begin
    #(200000 * PER);
    nfail++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    int gaps;
    int exp_q [$];

    // R1: reset holds the bus quiet
    rst = 1'b1;
    repeat (3) step();
    chk(out_valid == 1'b0, "R1", "valid in reset", out_valid, 0);
    chk(out_word == '0, "R1", "word in reset", out_word, 0);
    chk(col_adv == '0, "R1", "advance in reset", col_adv, 0);
    rst = 1'b0;
    step();
    chk(out_valid == 1'b0 && col_adv == '0, "R1", "quiet after reset", out_valid, 0);

    // R2 R5 R6: three columns loaded at once from idle
    clear_log();
    add_hits(0, 2); add_hits(5, 1); add_hits(21, 3);
    drain(gaps);
    chk(gaps == 2, "R2", "empty cycles before first hit", gaps, 2);
    exp_q = {ref_code(0), ref_code(0), ref_code(5), ref_code(21), ref_code(21), ref_code(21)};
    check_seq(exp_q, "R5");

    // R7 R6: requests below and above the token while a column talks
    clear_log();
    add_hits(10, 4);
    while (seq_codes.size() == 0) step();
    add_hits(3, 1); add_hits(15, 1);
    drain(gaps);
    chk(gaps == 4, "R6", "two empty cycles per sweep", gaps, 4);
    exp_q = {ref_code(10), ref_code(10), ref_code(10), ref_code(10), ref_code(15), ref_code(3)};
    check_seq(exp_q, "R7");

    // R9: every column once, back to back
    clear_log();
    for (int k = 0; k < NCOL; k++) add_hits(k, 1);
    drain(gaps);
    chk(gaps == 2, "R5", "no gap across all columns", gaps, 2);
    exp_q.delete();
    for (int k = 0; k < NCOL; k++) exp_q.push_back(ref_code(k));
    check_seq(exp_q, "R9");
    for (int i = 0; i < seq_codes.size(); i++)
      chk((seq_codes[i] % 4) != 0, "R9", "low code bits", seq_codes[i], 1);

    // R11: reset in the middle of a column
    clear_log();
    add_hits(2, 3);
    while (seq_codes.size() == 0) step();
    rst = 1'b1;
    step();
    rst = 1'b0;
    chk(out_valid == 1'b0, "R11", "token dropped by reset", out_valid, 0);
    clear_log();
    drain(gaps);
    chk(gaps == 2, "R11", "relaunch empty cycles", gaps, 2);
    exp_q = {ref_code(2)};
    check_seq(exp_q, "R11");

    // R4: a long single column keeps the token without gaps
    clear_log();
    add_hits(20, 9);
    drain(gaps);
    chk(gaps == 2, "R4", "empty cycles around long column", gaps, 2);
    chk(seq_codes.size() == 9, "R4", "hits delivered", seq_codes.size(), 9);

    summary();
    $finish;
  end
endmodule